// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This block is the NaN and invalid-operation stage of a floating-point arithmetic unit. Each cycle it looks at two operands (for a two-input operation) or three operands (for a fused multiply-add computing a*b+c). It decides whether the arithmetic result must be replaced by a NaN, and which NaN that is: one of the inputs, made quiet, or the default NaN. It also raises the Invalid exception flag. The normal arithmetic datapath runs alongside it and uses the override flag to choose between its own result and this block's result.

Two run-time controls shape the decision. A default-NaN enable forces every NaN result to the default NaN. An alternate-handling mode bit switches three things: the priority order among NaN operands, how 0*Inf plus a NaN addend is treated, and the sign of the default NaN. Both controls are sampled with the operands, so each operation uses the mode that came with it. The parameter `FMT` selects half (0), single (1) or double (2) precision. Outputs are registered, with a latency of one cycle.

Top module: `fpn_nan_select`

## Requirements
- R1: While `rst` is high at a clock edge, all three outputs are zero after that edge.
- R2: When no used operand is a NaN and there is no invalid product, the registered outputs are `nan_ovr_o`=0, `res_o`=0 and `invalid_o`=0.
- R3: In default mode (`alt_mode_i`=0), a two-input operation returns a signalling NaN in preference to a quiet one. Between NaNs of the same kind, A is preferred over B.
- R4: In default mode, a fused multiply-add prefers signalling NaNs over quiet ones. Between NaNs of the same kind, the order is C, then A, then B.
- R5: In default mode, a fused multiply-add whose product is zero times infinity (either order, either sign) returns a result that depends on the addend. A quiet-NaN addend gives the default NaN. A signalling-NaN addend gives that addend, made quiet. Invalid is raised in both cases.
- R6: The default NaN has all exponent bits set, only the top fraction bit set, and a sign bit equal to the mode bit. In single precision this is 0x7FC00000 in default mode and 0xFFC00000 in alternate mode.
- R7: In alternate mode, a two-input operation returns the first NaN in the order A, B, whether it is quiet or signalling.
- R8: In alternate mode, a fused multiply-add returns the first NaN in the order A, B, C, whether it is quiet or signalling.
- R9: In alternate mode, zero times infinity with a NaN addend returns that addend, made quiet. Invalid is raised only if the addend is signalling.
- R10: A returned input NaN has its top fraction bit forced to 1. Its sign, exponent and other fraction bits are kept. Every overridden result is therefore a quiet NaN.
- R11: Invalid is raised whenever a used operand is a signalling NaN. It is also raised when zero times infinity is added to a non-NaN addend, which returns the default NaN in either mode.
- R12: With `dn_mode_i`=1, every NaN result becomes the default NaN for the current mode. The Invalid flag is not changed.
- R13: Results appear one cycle after the inputs. A change of mode applies to the very operation it arrives with, even when operations run back to back.
- R14: In a two-input operation (`op_fma_i`=0), `opc_i` is ignored and no invalid-product check is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_fma_i | input | 1 | 1: fused multiply-add a*b+c; 0: two-input operation |
| dn_mode_i | input | 1 | Default-NaN enable |
| alt_mode_i | input | 1 | Alternate-handling mode bit |
| opa_i | input | W | Operand A (W = 16/32/64 by FMT) |
| opb_i | input | W | Operand B |
| opc_i | input | W | Operand C (addend) |
| nan_ovr_o | output | 1 | Result must be replaced by `res_o` |
| res_o | output | W | NaN result, zero when no override |
| invalid_o | output | 1 | Invalid exception flag |

## Verification
The operand patterns cover quiet and signalling NaNs placed in each of the three operand positions. These patterns are run in both modes, so a wrong priority order, or a missing signalling-over-quiet preference, shows up as a different payload at the output. Zero-times-infinity products are combined with quiet, signalling and ordinary addends, which separates the default-NaN, quieted-addend and Invalid-suppression outcomes of the two modes. Further directed cases cover the following: a signalling C in a two-input operation, the default-NaN enable, signed zeros and infinities, mode toggling on back-to-back cycles, and reset.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
    logic inf;
  } fpn_cls_t;

  typedef enum logic [1:0] {
    PICK_A = 2'd0,
    PICK_B = 2'd1,
    PICK_C = 2'd2
  } fpn_pick_e;

  function automatic int fmt_exp_w(input int fmt);
    case (fmt)
      0:       return 5;
      2:       return 11;
      default: return 8;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int fmt);
    case (fmt)
      0:       return 10;
      2:       return 52;
      default: return 23;
    endcase
  endfunction

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
  import fpn_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = 1 + EW + FW
) (
  input  logic [W-1:0] op,
  output fpn_cls_t     cls
);

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;
  logic          exp_max;
  logic          exp_min;
  logic          frac_nz;

  assign exp_f   = op[W-2:FW];
  assign frac_f  = op[FW-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls.nan  = exp_max & frac_nz;
    cls.snan = exp_max & frac_nz & ~frac_f[FW-1];
    cls.inf  = exp_max & ~frac_nz;
    cls.zero = exp_min & ~frac_nz;
  end

  // The sign bit plays no part in the class.
  logic unused_sign;
  assign unused_sign = op[W-1];

endmodule

// File: rtl/fpn_default_nan.sv
module fpn_default_nan #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = 1 + EW + FW
) (
  input  logic         alt,
  output logic [W-1:0] dnan
);

  // sign follows the mode bit; exponent all ones; only fraction MSB set
  assign dnan = {alt, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

endmodule

// File: rtl/fpn_decide.sv
module fpn_decide
  import fpn_pkg::*;
(
  input  fpn_cls_t  ca,
  input  fpn_cls_t  cb,
  input  fpn_cls_t  cc,
  input  logic      op_fma,
  input  logic      alt,
  output logic      ovr,
  output logic      use_dflt,
  output fpn_pick_e pick,
  output logic      inv
);

  logic prod_bad;
  assign prod_bad = op_fma & ((ca.zero & cb.inf) | (ca.inf & cb.zero));

  always_comb begin
    ovr      = 1'b0;
    use_dflt = 1'b0;
    pick     = PICK_A;
    inv      = 1'b0;
    if (op_fma) begin
      inv = ca.snan | cb.snan | cc.snan;
      if (prod_bad) begin
        ovr = 1'b1;
        if (cc.nan) begin
          pick = PICK_C;
          if (!alt) begin
            inv      = 1'b1;
            use_dflt = ~cc.snan;
          end
        end else begin
          use_dflt = 1'b1;
          inv      = 1'b1;
        end
      end else if (alt) begin
        if (ca.nan) begin
          ovr = 1'b1; pick = PICK_A;
        end else if (cb.nan) begin
          ovr = 1'b1; pick = PICK_B;
        end else if (cc.nan) begin
          ovr = 1'b1; pick = PICK_C;
        end
      end else begin
        if (cc.snan) begin
          ovr = 1'b1; pick = PICK_C;
        end else if (ca.snan) begin
          ovr = 1'b1; pick = PICK_A;
        end else if (cb.snan) begin
          ovr = 1'b1; pick = PICK_B;
        end else if (cc.nan) begin
          ovr = 1'b1; pick = PICK_C;
        end else if (ca.nan) begin
          ovr = 1'b1; pick = PICK_A;
        end else if (cb.nan) begin
          ovr = 1'b1; pick = PICK_B;
        end
      end
    end else begin
      inv = ca.snan | cb.snan;
      if (alt) begin
        if (ca.nan) begin
          ovr = 1'b1; pick = PICK_A;
        end else if (cb.nan) begin
          ovr = 1'b1; pick = PICK_B;
        end
      end else begin
        if (ca.snan) begin
          ovr = 1'b1; pick = PICK_A;
        end else if (cb.snan) begin
          ovr = 1'b1; pick = PICK_B;
        end else if (ca.nan) begin
          ovr = 1'b1; pick = PICK_A;
        end else if (cb.nan) begin
          ovr = 1'b1; pick = PICK_B;
        end
      end
    end
  end

  logic unused_cc;
  assign unused_cc = cc.zero ^ cc.inf;

endmodule

// File: rtl/fpn_nan_select.sv
module fpn_nan_select
  import fpn_pkg::*;
#(
  parameter int FMT = 1,
  localparam int EW = fmt_exp_w(FMT),
  localparam int FW = fmt_frac_w(FMT),
  localparam int W  = 1 + EW + FW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_fma_i,
  input  logic         dn_mode_i,
  input  logic         alt_mode_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] opc_i,
  output logic         nan_ovr_o,
  output logic [W-1:0] res_o,
  output logic         invalid_o
);

  localparam int NOPS = 3;
  localparam logic [W-1:0] QUIET_BIT = {{(W-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  logic [W-1:0] ops [NOPS];
  fpn_cls_t     cls [NOPS];

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;
  assign ops[2] = opc_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fpn_classify #(.EW(EW), .FW(FW)) u_cls (
      .op  (ops[g]),
      .cls (cls[g])
    );
  end

  logic      ovr_d;
  logic      use_dflt;
  fpn_pick_e pick;
  logic      inv_d;

  fpn_decide u_decide (
    .ca       (cls[0]),
    .cb       (cls[1]),
    .cc       (cls[2]),
    .op_fma   (op_fma_i),
    .alt      (alt_mode_i),
    .ovr      (ovr_d),
    .use_dflt (use_dflt),
    .pick     (pick),
    .inv      (inv_d)
  );

  logic [W-1:0] dnan;

  fpn_default_nan #(.EW(EW), .FW(FW)) u_dnan (
    .alt  (alt_mode_i),
    .dnan (dnan)
  );

  logic [W-1:0] picked;
  logic [W-1:0] res_d;

  always_comb begin
    case (pick)
      PICK_B:  picked = opb_i;
      PICK_C:  picked = opc_i;
      default: picked = opa_i;
    endcase
  end

  always_comb begin
    if (!ovr_d)                     res_d = '0;
    else if (use_dflt || dn_mode_i) res_d = dnan;
    else                            res_d = picked | QUIET_BIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nan_ovr_o <= 1'b0;
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      nan_ovr_o <= ovr_d;
      res_o     <= res_d;
      invalid_o <= inv_d;
    end
  end

  // ---------------- assertions ----------------
  localparam logic [W-1:0] DN_POS = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [W-1:0] DN_NEG = {1'b1, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic snan_used;
  logic ab_nan;
  logic prod_zi;
  assign snan_used = cls[0].snan | cls[1].snan | (op_fma_i & cls[2].snan);
  assign ab_nan    = cls[0].nan | cls[1].nan;
  assign prod_zi   = (cls[0].zero & cls[1].inf) | (cls[0].inf & cls[1].zero);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!nan_ovr_o && !invalid_o && res_o == '0));

  p_no_ovr_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !nan_ovr_o |-> res_o == '0);

  p_quiet_result_r10: assert property (@(posedge clk) disable iff (rst)
    nan_ovr_o |-> (&res_o[W-2:FW-1]));

  p_snan_invalid_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(snan_used)) |-> invalid_o);

  p_dn_replace_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(dn_mode_i) && nan_ovr_o)
      |-> res_o == ($past(alt_mode_i) ? DN_NEG : DN_POS));

  p_two_input_clean_r14: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!op_fma_i) && $past(!ab_nan)) |-> (!nan_ovr_o && !invalid_o));

  p_alt_qnan_addend_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_fma_i && alt_mode_i && prod_zi && cls[2].nan && !cls[2].snan))
      |-> (nan_ovr_o && !invalid_o));

  p_default_qnan_addend_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_fma_i && !alt_mode_i && prod_zi && cls[2].nan && !cls[2].snan))
      |-> (invalid_o && res_o == DN_POS));

endmodule

// File: tb/tb_fpn_nan_select.sv
`timescale 1ns/1ps
module tb_fpn_nan_select;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_fma_i = 1'b0;
  logic         dn_mode_i = 1'b0;
  logic         alt_mode_i = 1'b0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic [W-1:0] opc_i = '0;
  logic         nan_ovr_o;
  logic [W-1:0] res_o;
  logic         invalid_o;

  fpn_nan_select #(.FMT(1)) dut (
    .clk(clk), .rst(rst), .op_fma_i(op_fma_i), .dn_mode_i(dn_mode_i),
    .alt_mode_i(alt_mode_i), .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i),
    .nan_ovr_o(nan_ovr_o), .res_o(res_o), .invalid_o(invalid_o)
  );

  always #2.5 clk = ~clk;

  // operand constants (single precision)
  localparam logic [31:0] ONE  = 32'h3F80_0000;
  localparam logic [31:0] PZ   = 32'h0000_0000;
  localparam logic [31:0] NZ   = 32'h8000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000;
  localparam logic [31:0] QA   = 32'h7FC0_0011;
  localparam logic [31:0] SA   = 32'h7F80_0022;
  localparam logic [31:0] QSA  = 32'h7FC0_0022;
  localparam logic [31:0] QB   = 32'hFFC0_0033;
  localparam logic [31:0] SB   = 32'hFF80_0044;
  localparam logic [31:0] QSB  = 32'hFFC0_0044;
  localparam logic [31:0] QC   = 32'h7FC0_0055;
  localparam logic [31:0] SC   = 32'h7F80_0066;
  localparam logic [31:0] QSC  = 32'h7FC0_0066;
  localparam logic [31:0] DN0  = 32'h7FC0_0000;
  localparam logic [31:0] DN1  = 32'hFFC0_0000;

  // {fma, dn, alt, a, b, c, exp_ovr, exp_res, exp_inv}
  localparam int NV = 27;
  localparam int VW = 3 + 3*32 + 1 + 32 + 1;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0, ONE, ONE, SC,  1'b0, 32'h0, 1'b0}, // 0  R14
    {1'b0,1'b0,1'b0, QA,  QB,  ONE, 1'b1, QA,    1'b0}, // 1  R3
    {1'b0,1'b0,1'b0, QA,  SB,  ONE, 1'b1, QSB,   1'b1}, // 2  R3 R10
    {1'b0,1'b0,1'b0, SA,  SB,  ONE, 1'b1, QSA,   1'b1}, // 3  R3
    {1'b0,1'b0,1'b0, ONE, QB,  ONE, 1'b1, QB,    1'b0}, // 4  R3
    {1'b1,1'b0,1'b0, QA,  QB,  QC,  1'b1, QC,    1'b0}, // 5  R4
    {1'b1,1'b0,1'b0, SA,  QB,  QC,  1'b1, QSA,   1'b1}, // 6  R4
    {1'b1,1'b0,1'b0, QA,  SB,  SC,  1'b1, QSC,   1'b1}, // 7  R4
    {1'b1,1'b0,1'b0, QA,  QB,  ONE, 1'b1, QA,    1'b0}, // 8  R4
    {1'b1,1'b0,1'b0, ONE, QB,  ONE, 1'b1, QB,    1'b0}, // 9  R4
    {1'b1,1'b0,1'b0, PZ,  PINF,QC,  1'b1, DN0,   1'b1}, // 10 R5
    {1'b1,1'b0,1'b0, PINF,PZ,  SC,  1'b1, QSC,   1'b1}, // 11 R5
    {1'b1,1'b0,1'b0, PZ,  PINF,ONE, 1'b1, DN0,   1'b1}, // 12 R11 R6
    {1'b0,1'b0,1'b1, QA,  SB,  ONE, 1'b1, QA,    1'b1}, // 13 R7
    {1'b0,1'b0,1'b1, ONE, SB,  ONE, 1'b1, QSB,   1'b1}, // 14 R7
    {1'b1,1'b0,1'b1, QA,  SB,  SC,  1'b1, QA,    1'b1}, // 15 R8
    {1'b1,1'b0,1'b1, ONE, QB,  SC,  1'b1, QB,    1'b1}, // 16 R8
    {1'b1,1'b0,1'b1, ONE, ONE, QC,  1'b1, QC,    1'b0}, // 17 R8
    {1'b1,1'b0,1'b1, PZ,  PINF,QC,  1'b1, QC,    1'b0}, // 18 R9
    {1'b1,1'b0,1'b1, PINF,PZ,  SC,  1'b1, QSC,   1'b1}, // 19 R9
    {1'b1,1'b0,1'b1, PZ,  PINF,ONE, 1'b1, DN1,   1'b1}, // 20 R6 R11
    {1'b1,1'b1,1'b0, SA,  QB,  QC,  1'b1, DN0,   1'b1}, // 21 R12
    {1'b0,1'b1,1'b1, QA,  QB,  ONE, 1'b1, DN1,   1'b0}, // 22 R12
    {1'b0,1'b1,1'b0, ONE, ONE, ONE, 1'b0, 32'h0, 1'b0}, // 23 R12
    {1'b1,1'b0,1'b0, ONE, ONE, ONE, 1'b0, 32'h0, 1'b0}, // 24 R2
    {1'b0,1'b0,1'b0, PINF,PZ,  QC,  1'b0, 32'h0, 1'b0}, // 25 R14
    {1'b1,1'b0,1'b0, NZ,  NINF,ONE, 1'b1, DN0,   1'b1}  // 26 R11 signed
  };

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic ao, input logic [31:0] ar,
                       input logic ai, input logic eo, input logic [31:0] er,
                       input logic ei);
    total++;
    if (ao !== eo || ar !== er || ai !== ei) begin
      bad++;
      $display("FAIL %s: got ovr=%0b res=%h inv=%0b, expected ovr=%0b res=%h inv=%0b",
               req, ao, ar, ai, eo, er, ei);
    end
  endtask

  task automatic apply(input logic f, input logic d, input logic al,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    op_fma_i = f; dn_mode_i = d; alt_mode_i = al;
    opa_i = a; opb_i = b; opc_i = c;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, with NaN inputs present
    apply(1'b1, 1'b0, 1'b0, SA, SB, SC);
    apply(1'b1, 1'b0, 1'b0, SA, SB, SC);
    check("R1 reset", nan_ovr_o, res_o, invalid_o, 1'b0, 32'h0, 1'b0);
    rst = 1'b0;

    // table walk: one vector per cycle, result checked one cycle later (R13)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[VW-1], v[VW-2], v[VW-3], v[VW-4 -: 32], v[VW-36 -: 32], v[VW-68 -: 32]);
      check($sformatf("vec%0d R2-R14 table", i), nan_ovr_o, res_o, invalid_o,
            v[33], v[32:1], v[0]);
    end

    // R13: mode toggled on consecutive operations with identical operands
    apply(1'b1, 1'b0, 1'b0, QA, QB, SC);
    check("R13 default", nan_ovr_o, res_o, invalid_o, 1'b1, QSC, 1'b1);
    apply(1'b1, 1'b0, 1'b1, QA, QB, SC);
    check("R13 alternate", nan_ovr_o, res_o, invalid_o, 1'b1, QA, 1'b1);
    apply(1'b1, 1'b0, 1'b0, QA, QB, SC);
    check("R13 back to default", nan_ovr_o, res_o, invalid_o, 1'b1, QSC, 1'b1);

    // R10: payload and sign preserved on quieting (negative signalling A)
    apply(1'b0, 1'b0, 1'b0, 32'hFFA5_5AA5, ONE, ONE);
    check("R10 quiet keeps payload", nan_ovr_o, res_o, invalid_o, 1'b1, 32'hFFE5_5AA5, 1'b1);

    // R6: default NaN sign follows mode with dn enable
    apply(1'b0, 1'b1, 1'b1, ONE, SB, ONE);
    check("R6 alt default NaN", nan_ovr_o, res_o, invalid_o, 1'b1, DN1, 1'b1);

    // R1: reset mid-run clears outputs
    rst = 1'b1;
    apply(1'b1, 1'b0, 1'b0, SA, QB, QC);
    check("R1 reset mid-run", nan_ovr_o, res_o, invalid_o, 1'b0, 32'h0, 1'b0);
    rst = 1'b0;
    apply(1'b1, 1'b0, 1'b0, SA, QB, QC);
    check("R4 after reset", nan_ovr_o, res_o, invalid_o, 1'b1, QSA, 1'b1);

    finish_run();
  end

endmodule